// File: doc/BRIEF.md
# Framed Hex UART Block Dumper

This block sends a captured block of samples from a sample RAM to a host as readable ASCII hexadecimal text over a UART line. A start request is accepted only while the block is idle. When it is accepted, the block sends a header packet and then one packet for each sample slot. Every packet holds five 16-bit values, and each value is written as four hex characters. A marker character opens each packet and a closing character ends it.

The busy output stays high for the whole dump. The capture side uses it to stop writing the RAM while the dump is running. The two header values come from the capture side's counters and are taken at the moment the request is accepted. The number of slots comes from a run-time length input, which is also taken at that moment. The RAM is read through a synchronous port with one cycle of latency. Slot k holds its five values at consecutive addresses starting at 5*k.

Top module: `hex_block_dumper`

## Requirements
- R1: After reset, `busy` is low and `txLine` is high. Whenever `busy` is low, `txLine` is high.
- R2: Each character goes out as one UART frame: a low start bit, then eight data bits with the LSB first, then a high stop bit. Every bit lasts 16*PRESCALE clock cycles.
- R3: A `startReq` sampled while idle makes `busy` high from the next cycle on. `busy` stays high until the stop bit of the last character has ended. `busy` never rises without a request.
- R4: The first packet is 'U' (0x55), then the header values 0, `hdrIndex`, `hdrCount`, 0, 0, then 'X' (0x58). The header values are the ones present in the cycle the request is accepted.
- R5: For slot k (counting from 0), the data packet is 'Y' (0x59), then the RAM words at addresses 5*k to 5*k+4 in rising address order, then 'X' (0x58).
- R6: Each value is sent as four uppercase hex digits, most significant nibble first. Digits 0-9 are 0x30-0x39 and digits A-F are 0x41-0x46.
- R7: The number of data packets equals `blockLen` as sampled at acceptance. A value of 0 sends the header packet only.
- R8: A `startReq` that arrives during a dump has no effect. No packet is added and no character changes.
- R9: If `startReq` stays high through the end of a dump, the next dump starts after `busy` has been low for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request to begin a dump |
| blockLen | input | SLOT_W+1 | Number of sample slots to send |
| hdrIndex | input | 16 | Sample index counter placed in the header |
| hdrCount | input | 16 | Samples-since-last-dump counter placed in the header |
| ramAddr | output | RAM_AW | Read address of the sample RAM |
| ramData | input | 16 | Read data, valid one cycle after the address |
| txLine | output | 1 | Serial output, high when idle |
| busy | output | 1 | High for the whole dump |

## Verification
The end of one dump and a new start request can fall in the same cycle. The bench provokes this by holding `startReq` high across the final stop bit. It then counts the low cycles of `busy` between the two dumps, which must be exactly one. The scoreboard must see both complete character streams back to back. A second overlap is a request or a header change that arrives while a dump is running. This is judged by confirming that the character stream still carries the values latched at acceptance, and that no extra packet appears.

// File: rtl/hexdump_pkg.sv
package hexdump_pkg;
  localparam int PKT_VALS = 5;
  localparam int VAL_W = $clog2(PKT_VALS);
  localparam int NIBS = 4;

  typedef enum logic [1:0] {CK_OPEN_FIRST, CK_OPEN_NEXT, CK_DIGIT, CK_CLOSE} charKind_e;

  typedef struct packed {
    logic latchHdr;
    logic loadVal;
    logic sendChar;
    logic fromHdr;
    charKind_e kind;
    logic [1:0] nib;
    logic [VAL_W-1:0] valIdx;
  } dpStrobe_t;
endpackage

// File: rtl/hexdump_datapath.sv
module hexdump_datapath
  import hexdump_pkg::*;
#(
  parameter int PRESCALE = 27
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strb,
  input  logic [15:0] hdrIndex,
  input  logic [15:0] hdrCount,
  input  logic [15:0] ramData,
  output logic        txLine,
  output logic        uartBusy
);
  localparam int BIT_CYC = 16 * PRESCALE;
  localparam int TMR_W = $clog2(BIT_CYC + 1);

  logic [15:0] hdrIdxQ, hdrCntQ, valReg, hdrVal;
  logic [3:0] nibble;
  logic [7:0] charCode;
  logic [9:0] shiftReg;
  logic [3:0] bitsLeft;
  logic [TMR_W-1:0] tmr;

  always_comb begin
    case (strb.valIdx)
      VAL_W'(1): hdrVal = hdrIdxQ;
      VAL_W'(2): hdrVal = hdrCntQ;
      default:   hdrVal = '0;
    endcase
    case (strb.nib)
      2'd0: nibble = valReg[15:12];
      2'd1: nibble = valReg[11:8];
      2'd2: nibble = valReg[7:4];
      default: nibble = valReg[3:0];
    endcase
    case (strb.kind)
      CK_OPEN_FIRST: charCode = 8'h55;
      CK_OPEN_NEXT:  charCode = 8'h59;
      CK_CLOSE:      charCode = 8'h58;
      default:       charCode = (nibble < 4'd10) ? (8'h30 + {4'd0, nibble})
                                                 : (8'h37 + {4'd0, nibble});
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrIdxQ <= '0;
      hdrCntQ <= '0;
      valReg  <= '0;
    end else begin
      if (strb.latchHdr) begin
        hdrIdxQ <= hdrIndex;
        hdrCntQ <= hdrCount;
      end
      if (strb.loadVal) valReg <= strb.fromHdr ? hdrVal : ramData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      bitsLeft <= '0;
      tmr      <= '0;
      uartBusy <= 1'b0;
    end else if (!uartBusy) begin
      if (strb.sendChar) begin
        shiftReg <= {1'b1, charCode, 1'b0};
        bitsLeft <= 4'd10;
        tmr      <= '0;
        uartBusy <= 1'b1;
      end
    end else if (tmr == TMR_W'(BIT_CYC - 1)) begin
      tmr      <= '0;
      shiftReg <= {1'b1, shiftReg[9:1]};
      bitsLeft <= bitsLeft - 4'd1;
      if (bitsLeft == 4'd1) uartBusy <= 1'b0;
    end else begin
      tmr <= tmr + TMR_W'(1);
    end
  end

  assign txLine = uartBusy ? shiftReg[0] : 1'b1;
endmodule

// File: rtl/hexdump_ctrl.sv
module hexdump_ctrl
  import hexdump_pkg::*;
#(
  parameter int SLOT_W = 9,
  parameter int RAM_AW = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [SLOT_W:0]   blockLen,
  input  logic              uartBusy,
  output dpStrobe_t         strb,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              busy
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LOAD, S_SEND, S_WAIT} state_e;
  typedef enum logic [1:0] {P_OPEN, P_DIGIT, P_CLOSE} phase_e;

  state_e state;
  phase_e phase;
  logic [SLOT_W:0] pkt, lenQ;
  logic [VAL_W-1:0] valIdx;
  logic [1:0] nib;
  logic [RAM_AW-1:0] base;

  always_comb begin
    strb.latchHdr = (state == S_IDLE) && startReq;
    strb.loadVal  = (state == S_LOAD);
    strb.sendChar = (state == S_SEND);
    strb.fromHdr  = (pkt == '0);
    strb.nib      = nib;
    strb.valIdx   = valIdx;
    case (phase)
      P_OPEN:  strb.kind = (pkt == '0) ? CK_OPEN_FIRST : CK_OPEN_NEXT;
      P_DIGIT: strb.kind = CK_DIGIT;
      default: strb.kind = CK_CLOSE;
    endcase
  end

  assign ramAddr = base + RAM_AW'(valIdx);
  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      phase  <= P_OPEN;
      pkt    <= '0;
      lenQ   <= '0;
      valIdx <= '0;
      nib    <= '0;
      base   <= '0;
    end else begin
      case (state)
        S_IDLE: if (startReq) begin
          lenQ   <= blockLen;
          pkt    <= '0;
          base   <= '0;
          valIdx <= '0;
          nib    <= '0;
          phase  <= P_OPEN;
          state  <= S_SEND;
        end
        S_FETCH: state <= S_LOAD;
        S_LOAD:  state <= S_SEND;
        S_SEND:  state <= S_WAIT;
        S_WAIT: if (!uartBusy) begin
          case (phase)
            P_OPEN: begin
              phase  <= P_DIGIT;
              valIdx <= '0;
              nib    <= '0;
              state  <= S_FETCH;
            end
            P_DIGIT: begin
              if (nib == 2'd3) begin
                nib <= '0;
                if (valIdx == VAL_W'(PKT_VALS - 1)) begin
                  phase <= P_CLOSE;
                  state <= S_SEND;
                end else begin
                  valIdx <= valIdx + VAL_W'(1);
                  state  <= S_FETCH;
                end
              end else begin
                nib   <= nib + 2'd1;
                state <= S_SEND;
              end
            end
            default: begin
              if (pkt == lenQ) begin
                state <= S_IDLE;
              end else begin
                if (pkt != '0) base <= base + RAM_AW'(PKT_VALS);
                pkt    <= pkt + 1'b1;
                valIdx <= '0;
                phase  <= P_OPEN;
                state  <= S_SEND;
              end
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hex_block_dumper.sv
module hex_block_dumper
  import hexdump_pkg::*;
#(
  parameter int SLOT_W   = 9,
  parameter int PRESCALE = 27,
  localparam int RAM_AW  = $clog2(PKT_VALS * (2 ** SLOT_W))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [SLOT_W:0]   blockLen,
  input  logic [15:0]       hdrIndex,
  input  logic [15:0]       hdrCount,
  output logic [RAM_AW-1:0] ramAddr,
  input  logic [15:0]       ramData,
  output logic              txLine,
  output logic              busy
);
  dpStrobe_t strb;
  logic uartBusy;

  hexdump_ctrl #(.SLOT_W(SLOT_W), .RAM_AW(RAM_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .blockLen(blockLen),
    .uartBusy(uartBusy), .strb(strb), .ramAddr(ramAddr), .busy(busy)
  );

  hexdump_datapath #(.PRESCALE(PRESCALE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hdrIndex(hdrIndex),
    .hdrCount(hdrCount), .ramData(ramData), .txLine(txLine),
    .uartBusy(uartBusy)
  );
endmodule

// File: rtl/hexdump_checker.sv
module hexdump_checker #(
  parameter int SLOT_W = 9,
  parameter int RAM_AW = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              busy,
  input logic              txLine,
  input logic [RAM_AW-1:0] ramAddr
);
  localparam int ADDR_LIMIT = 5 * (2 ** SLOT_W);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine); // R1
  AST_FRAME_IN_DUMP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txLine) |-> busy); // R2
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> busy); // R3
  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq)); // R3
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (32'(ramAddr) < ADDR_LIMIT)); // R5
endmodule

bind hex_block_dumper hexdump_checker #(.SLOT_W(SLOT_W), .RAM_AW(RAM_AW)) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .busy(busy),
  .txLine(txLine), .ramAddr(ramAddr)
);

// File: tb/hex_block_dumper_bench.sv
module hex_block_dumper_bench;
  localparam int SLOT_W = 3;
  localparam int PRESCALE = 1;
  localparam int BITC = 16 * PRESCALE;
  localparam int AW = $clog2(5 * (2 ** SLOT_W));
  localparam int WORDS = 5 * (2 ** SLOT_W);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [SLOT_W:0] blockLen = '0;
  logic [15:0] hdrIndex = '0, hdrCount = '0;
  logic [AW-1:0] ramAddr;
  logic [15:0] ramData;
  logic txLine, busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic [15:0] mem [0:WORDS-1];

  always #4 clk = ~clk;

  hex_block_dumper #(.SLOT_W(SLOT_W), .PRESCALE(PRESCALE)) u_hex_block_dumper (
    .clk(clk), .rstN(rstN), .startReq(startReq), .blockLen(blockLen),
    .hdrIndex(hdrIndex), .hdrCount(hdrCount), .ramAddr(ramAddr),
    .ramData(ramData), .txLine(txLine), .busy(busy)
  );

  always_ff @(posedge clk) ramData <= mem[ramAddr];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hexCh(input logic [3:0] d);
    return (d < 4'd10) ? (8'h30 + {4'd0, d}) : (8'h41 + {4'd0, d} - 8'd10);
  endfunction

  task automatic pushVal(input logic [15:0] v, input string tag);
    for (int i = 3; i >= 0; i--) begin
      expQ.push_back(hexCh(v[i*4 +: 4]));
      tagQ.push_back(tag);
    end
  endtask

  // driver: expected character stream of one dump
  task automatic expectDump(input logic [15:0] hi, input logic [15:0] hc, input int n);
    expQ.push_back(8'h55); tagQ.push_back("R4");
    pushVal(16'h0, "R4"); pushVal(hi, "R4"); pushVal(hc, "R4");
    pushVal(16'h0, "R4"); pushVal(16'h0, "R4");
    expQ.push_back(8'h58); tagQ.push_back("R4");
    for (int k = 0; k < n; k++) begin
      expQ.push_back(8'h59); tagQ.push_back("R5");
      for (int c = 0; c < 5; c++) pushVal(mem[k*5 + c], "R6");
      expQ.push_back(8'h58); tagQ.push_back("R5");
    end
  endtask

  // monitor: decode UART frames and compare against the scoreboard
  initial begin
    logic [7:0] rx;
    forever begin
      @(negedge clk);
      if (rstN && txLine == 1'b0) begin
        repeat (BITC/2) @(negedge clk);
        check(txLine == 1'b0, "R2 start bit", txLine, 0);
        for (int b = 0; b < 8; b++) begin
          repeat (BITC) @(negedge clk);
          rx[b] = txLine;
        end
        repeat (BITC) @(negedge clk);
        check(txLine == 1'b1, "R2 stop bit", txLine, 1);
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected char", rx, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(rx == e, t, rx, e);
        end
      end
    end
  end

  task automatic waitIdle();
    int guard = 0;
    @(negedge clk);
    while (busy && guard < 100000) begin
      @(negedge clk);
      guard++;
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1, "R3 busy after start", busy, 1);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = 16'(i * 16'h3B17 + 16'h0A09);
    mem[5] = 16'hFFFF;
    mem[6] = 16'h0000;
    mem[7] = 16'hABCD;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(txLine == 1'b1, "R1 line in reset", txLine, 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && txLine == 1'b1, "R1 idle after reset", {busy, txLine}, 1);

    // two slots; header inputs change and a request arrives mid-dump
    hdrIndex = 16'h1234; hdrCount = 16'h9F0E; blockLen = 2;
    expectDump(16'h1234, 16'h9F0E, 2);
    pulseStart();
    repeat (300) @(negedge clk);
    hdrIndex = 16'h5555; hdrCount = 16'h6666; blockLen = 5;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitIdle();
    check(expQ.size() == 0, "R8 R7 stream length", expQ.size(), 0);
    check(busy == 1'b0, "R3 busy after dump", busy, 0);

    // header only
    hdrIndex = 16'hC0DE; hdrCount = 16'h0001; blockLen = 0;
    expectDump(16'hC0DE, 16'h0001, 0);
    pulseStart();
    waitIdle();
    check(expQ.size() == 0, "R7 header only", expQ.size(), 0);

    // full depth
    hdrIndex = 16'h01FF; hdrCount = 16'h0200; blockLen = 8;
    expectDump(16'h01FF, 16'h0200, 8);
    pulseStart();
    waitIdle();
    check(expQ.size() == 0, "R7 full block", expQ.size(), 0);

    // request held across the end of a dump
    hdrIndex = 16'h7E7E; hdrCount = 16'h00A5; blockLen = 1;
    expectDump(16'h7E7E, 16'h00A5, 1);
    expectDump(16'h7E7E, 16'h00A5, 1);
    begin
      int low = 0;
      int guard = 0;
      @(negedge clk);
      startReq = 1'b1;
      @(negedge clk);
      while (busy && guard < 100000) begin @(negedge clk); guard++; end
      while (!busy && low < 50) begin @(negedge clk); low++; end
      startReq = 1'b0;
      check(low == 1, "R9 idle gap cycles", low, 1);
    end
    waitIdle();
    check(expQ.size() == 0, "R9 both dumps sent", expQ.size(), 0);
    check(txLine == 1'b1, "R1 line idle at end", txLine, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule